// File: doc/BRIEF.md
# Bit Test and Modify Unit

This unit performs single-bit test operations on a 16-bit or 32-bit destination word. It takes the destination value, a bit position and an operation code. It returns the value of the chosen bit as a carry flag, the destination with that bit left alone, inverted, cleared or set, and a write-enable that tells the register file whether the new value must be stored. The bit position comes from an 8-bit immediate or from a general register. A select input chooses the source.

The caller drives a strobe with each request. The results are registered and appear one clock later with a matching valid. The position wraps to the operand size, so an out-of-range index picks a bit inside the word. It never spills past the word.

Top module: `bitop_unit`

## Requirements
- R1: On every accepted request, out_cf equals the selected destination bit as it was before any change, whatever the operation.
- R2: The bit position comes from imm_idx when idx_sel is 0 and from reg_idx when idx_sel is 1.
- R3: With wide=0 the position is the source's low 4 bits. With wide=1 it is the source's low 5 bits.
- R4: Operation 2'b00 (test) returns the destination unchanged and drives out_we low.
- R5: Operation 2'b01 (complement) inverts the selected bit and changes no other bit.
- R6: Operation 2'b10 (reset) clears the selected bit and changes no other bit.
- R7: Operation 2'b11 (set) sets the selected bit and changes no other bit.
- R8: out_we is high exactly when out_valid is high and the request's operation was 01, 10 or 11.
- R9: out_valid is in_valid delayed by one clock. In a cycle after no strobe, out_we is low and out_data and out_cf keep their previous values.
- R10: While rst_n is low, out_valid, out_we, out_cf and out_data are all zero.
- R11: With wide=0, bits 31:16 of out_data equal bits 31:16 of the destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| in_dest | input | 32 | Destination operand |
| idx_sel | input | 1 | 0 selects immediate index, 1 selects register index |
| imm_idx | input | 8 | Immediate bit index |
| reg_idx | input | 32 | Register bit index |
| op | input | 2 | 00 test, 01 complement, 10 reset, 11 set |
| wide | input | 1 | 0 for 16-bit operand, 1 for 32-bit operand |
| out_valid | output | 1 | Result valid, one clock after in_valid |
| out_data | output | 32 | Modified destination |
| out_we | output | 1 | Destination write-enable |
| out_cf | output | 1 | New carry flag |

## Verification
Some properties are checked by assertions on every cycle:
- the position mask is one-hot;
- out_valid follows in_valid by one clock;
- the write-enable appears only together with a valid result;
- each operation's effect on the result, measured against the previous cycle's destination and mask: no change for test, exactly the mask bit differing for complement, the masked bit clear for reset and set for set.

Other properties only the bench scenarios can show:
- that the carry holds the bit from before the change;
- that the index source and the wrap to the operand width are right;
- that the upper half passes through untouched in 16-bit mode;
- that the outputs hold across idle cycles.

// File: rtl/bitop_pkg.sv
package bitop_pkg;

  typedef enum logic [1:0] {
    OP_TEST = 2'b00,
    OP_COMP = 2'b01,
    OP_CLR  = 2'b10,
    OP_SET  = 2'b11
  } bitop_e;

  // Value of the bit under a one-hot mask.
  function automatic logic pick_bit(input logic [31:0] data, input logic [31:0] mask);
    return |(data & mask);
  endfunction

  // Word after the operation is applied at the masked position.
  function automatic logic [31:0] apply_op(input bitop_e op, input logic [31:0] data,
                                           input logic [31:0] mask);
    logic [31:0] r;
    case (op)
      OP_COMP: r = data ^ mask;
      OP_CLR:  r = data & ~mask;
      OP_SET:  r = data | mask;
      default: r = data;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/bitop_index.sv
module bitop_index #(
  parameter int DW = 32,
  parameter int IW = 8,
  localparam int PW = $clog2(DW)
) (
  input  logic          idx_sel,
  input  logic [PW-1:0] imm_pos,
  input  logic [PW-1:0] reg_pos,
  input  logic          wide,
  output logic [PW-1:0] pos,
  output logic [DW-1:0] mask
);
  logic [PW-1:0] raw;

  // R2: choose the index source.
  assign raw = idx_sel ? reg_pos : imm_pos;

  // R3: wrap to the operand width.
  assign pos = wide ? raw : {1'b0, raw[PW-2:0]};

  for (genvar i = 0; i < DW; i++) begin : g_mask
    assign mask[i] = (pos == PW'(i));
  end

  always_comb begin
    a_r3_mask_onehot : assert (^mask === 1'bx || $onehot(mask));
  end

  logic unused_iw;
  assign unused_iw = (IW > 0);
endmodule

// File: rtl/bitop_alu.sv
module bitop_alu
  import bitop_pkg::*;
#(
  parameter int DW = 32
) (
  input  bitop_e        op,
  input  logic [DW-1:0] dest,
  input  logic [DW-1:0] mask,
  output logic [DW-1:0] result,
  output logic          cf,
  output logic          we
);
  // R1: the carry comes from the untouched operand.
  assign cf     = pick_bit(dest, mask);
  assign result = apply_op(op, dest, mask);
  assign we     = (op != OP_TEST);

  always_comb begin
    if (op == OP_TEST && !$isunknown(dest))
      a_r4_test_passthru : assert (result == dest);
  end
endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
  import bitop_pkg::*;
#(
  parameter int DW = 32,
  parameter int IW = 8,
  localparam int PW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_dest,
  input  logic          idx_sel,
  input  logic [IW-1:0] imm_idx,
  input  logic [DW-1:0] reg_idx,
  input  logic [1:0]    op,
  input  logic          wide,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          out_we,
  output logic          out_cf
);
  logic [PW-1:0] pos;
  logic [DW-1:0] mask;
  logic [DW-1:0] alu_result;
  logic          alu_cf;
  logic          alu_we;
  bitop_e        op_e;

  assign op_e = bitop_e'(op);

  bitop_index #(.DW(DW), .IW(IW)) u_index (
    .idx_sel (idx_sel),
    .imm_pos (imm_idx[PW-1:0]),
    .reg_pos (reg_idx[PW-1:0]),
    .wide    (wide),
    .pos     (pos),
    .mask    (mask)
  );

  bitop_alu #(.DW(DW)) u_alu (
    .op     (op_e),
    .dest   (in_dest),
    .mask   (mask),
    .result (alu_result),
    .cf     (alu_cf),
    .we     (alu_we)
  );

  logic unused_hi;
  assign unused_hi = ^{reg_idx[DW-1:PW], imm_idx[IW-1:PW], pos};

  // R9, R10: output register.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_we    <= 1'b0;
      out_cf    <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      out_we    <= in_valid & alu_we;
      if (in_valid) begin
        out_data <= alu_result;
        out_cf   <= alu_cf;
      end
    end
  end

  a_r9_latency : assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> out_valid == $past(in_valid));

  a_r8_we_needs_valid : assert property (@(posedge clk) disable iff (!rst_n)
    out_we |-> out_valid);

  a_r5_comp_one_bit : assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 2'b01) |=> (out_data ^ $past(in_dest)) == $past(mask));

  a_r6_clr_bit : assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 2'b10) |=> (out_data & $past(mask)) == '0);

  a_r7_set_bit : assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 2'b11) |=> (out_data & $past(mask)) == $past(mask));

  a_r4_test_no_write : assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 2'b00) |=> (!out_we && out_data == $past(in_dest)));
endmodule

// File: tb/bitop_unit_bench.sv
module bitop_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_dest = '0;
  logic        idx_sel = 1'b0;
  logic [7:0]  imm_idx = '0;
  logic [31:0] reg_idx = '0;
  logic [1:0]  op = '0;
  logic        wide = 1'b0;
  logic        out_valid, out_we, out_cf;
  logic [31:0] out_data;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bitop_unit u_bitop_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dest(in_dest),
    .idx_sel(idx_sel), .imm_idx(imm_idx), .reg_idx(reg_idx), .op(op),
    .wide(wide), .out_valid(out_valid), .out_data(out_data),
    .out_we(out_we), .out_cf(out_cf)
  );

  function automatic int exp_pos(input bit sel, input logic [7:0] imm,
                                 input logic [31:0] rg, input bit w);
    int src;
    src = sel ? int'(rg % 256) : int'(imm);
    return w ? (src % 32) : (src % 16);
  endfunction

  function automatic logic [31:0] exp_data(input logic [1:0] o, input logic [31:0] d, input int p);
    logic [31:0] r;
    r = d;
    if (o == 2'd1) r[p] = ~d[p];
    else if (o == 2'd2) r[p] = 1'b0;
    else if (o == 2'd3) r[p] = 1'b1;
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One request, checked one clock later.
  task automatic run_op(input logic [31:0] d, input bit sel, input logic [7:0] imm,
                        input logic [31:0] rg, input logic [1:0] o, input bit w, input string req);
    int p;
    logic [31:0] ed;
    p  = exp_pos(sel, imm, rg, w);
    ed = exp_data(o, d, p);
    @(negedge clk);
    in_valid = 1'b1; in_dest = d; idx_sel = sel; imm_idx = imm;
    reg_idx = rg; op = o; wide = w;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " R1 cf"}, {31'd0, out_cf}, {31'd0, d[p]});
    check({req, " data"}, out_data, ed);
    check({req, " R8 we"}, {31'd0, out_we}, {31'd0, o != 2'd0});
    check({req, " R9 valid"}, {31'd0, out_valid}, 32'd1);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] hd;
    logic        hc;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 valid", {31'd0, out_valid}, 32'd0);
    check("R10 we", {31'd0, out_we}, 32'd0);
    check("R10 cf", {31'd0, out_cf}, 32'd0);
    check("R10 data", out_data, 32'd0);
    rst_n = 1'b1;

    run_op(32'h0000_0010, 1'b0, 8'd4,  32'd0,  2'd0, 1'b1, "R4 test");
    run_op(32'hFFFF_FFFF, 1'b0, 8'd31, 32'd0,  2'd1, 1'b1, "R5 comp top bit");
    run_op(32'h0000_0000, 1'b1, 8'd0,  32'd7,  2'd3, 1'b1, "R2 R7 reg src set");
    run_op(32'h8000_8000, 1'b0, 8'd31, 32'd0,  2'd2, 1'b0, "R3 R6 wrap16 clr");
    run_op(32'hABCD_0000, 1'b0, 8'd20, 32'd0,  2'd3, 1'b0, "R11 upper kept");
    run_op(32'h0000_0001, 1'b1, 8'd5,  32'h120, 2'd2, 1'b1, "R2 R3 reg wrap32");
    run_op(32'h5555_5555, 1'b0, 8'd255, 32'd0, 2'd1, 1'b1, "R3 imm 255");

    // R9 hold across an idle cycle
    hd = out_data; hc = out_cf;
    @(negedge clk);
    check("R9 idle valid", {31'd0, out_valid}, 32'd0);
    check("R9 idle we", {31'd0, out_we}, 32'd0);
    check("R9 idle data", out_data, hd);
    check("R9 idle cf", {31'd0, out_cf}, {31'd0, hc});

    for (int k = 0; k < 400; k++) begin
      run_op($urandom, 1'($urandom), 8'($urandom), $urandom, 2'($urandom),
             1'($urandom), "rand R1 R5 R6 R7 R11");
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule